// File: doc/BRIEF.md
# Fine-Tunable Nanosecond Time Counter

This block is a free-running hardware time base for a precision time protocol. Each clock cycle of its reference clock is one nominal 8 ns tick, and on every tick the block adds a fixed 8 ns to a 40-bit nanosecond count. A sign-magnitude trim value feeds a 32-bit fractional accumulator. Whenever that accumulator carries out, the tick adds one nanosecond more or one nanosecond less, so software can steer the rate in steps of 2^-32 ns per tick. A trim of P parts per billion corresponds to a magnitude of P*2^26/1953125.

Software reaches the block through a simple word-wide register bus. A three-word time view is spread over consecutive addresses: the sub-nanosecond residue first, then the low nanoseconds, then the high nanoseconds. Reading the residue word freezes a copy of the whole count, so the two later words always belong to the same instant. A new count is staged through the low word and is committed as a whole when the high word is written. The live 40-bit count is also driven out directly for timestamp capture logic. The count wraps roughly every 18.3 minutes, and software is expected to extend it.

Top module: `ns_time_counter`

## Requirements
- R1: After reset the count, the residue and the trim are zero, the halt bit (bit 31 of the control word at address 4) reads as 1, `halt_o` is 1, and `reg_rdata` is zero.
- R2: While the halt bit is 1 the count holds its value, except when a new count is loaded.
- R3: While running with a trim magnitude of zero (trim word at address 3, bits 30:0), the count advances by exactly 8 every clock.
- R4: With trim sign 0 (bit 31 of the trim word), each tick adds the magnitude to the 32-bit residue, and a tick whose addition carries out of 32 bits advances the count by 9 instead of 8.
- R5: With trim sign 1, a tick whose residue addition carries out advances the count by 7 instead of 8.
- R6: A read of the high word (address 2) returns count bits 39:32 in bits 7:0 and zero in bits 31:8. The count wraps modulo 2^40.
- R7: A read of the residue word (address 0) captures the whole count. Later reads of the low word (address 1) and the high word return that captured value until the next residue read, however far the live count has moved.
- R8: A write to the low word changes neither the count nor the residue. A following write to the high word loads {high[7:0], low} into the count and clears the residue, both at the same clock edge.
- R9: Read data appears on `reg_rdata` in the clock cycle after the cycle in which `reg_rd` is high.
- R10: A read of the residue word returns the fractional accumulator, and a write to the residue word is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; each rising edge is one 8 ns tick |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Word address: 0 residue, 1 low ns, 2 high ns, 3 trim, 4 control |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| halt_o | output | 1 | Current halt bit; the count holds while it is 1 |
| time_ns | output | 40 | Live nanosecond count |

## Verification
The step-size properties assume that a count load is the only event that can make the count jump. They hold the bounds 7..9, or exactly 8 for a zero trim, only for cycles without a high-word write, and they treat halt as a plain held state. The stimulus never asserts read and write in the same cycle, writes the trim only while halted, and changes the halt bit only through the control word. The expected counts can therefore be derived from a count of ticks that depends on the cycle. The snapshot property assumes that only a residue read may change the captured copy, and the bench keeps the live count moving between the capture and the later word reads to show this.

// File: rtl/ns_time_counter.sv
module ns_time_counter #(
  parameter int NS_W    = 40,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int STEP_NS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              halt_o,
  output logic [NS_W-1:0]   time_ns
);
  localparam int HI_W  = NS_W - DATA_W;
  localparam int MAG_W = DATA_W - 1;
  localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_TRIM = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_AUX  = ADDR_W'(4);

  logic [NS_W-1:0]   ns_q, snap_q, step;
  logic [DATA_W-1:0] frac_q, trim_q, lo_stage_q;
  logic              halt_q;
  logic [DATA_W:0]   frac_sum;

  wire load     = reg_wr && (reg_addr == A_HI);
  wire trim_neg = trim_q[DATA_W-1];

  assign frac_sum = {1'b0, frac_q} + {2'b00, trim_q[MAG_W-1:0]};

  always_comb begin
    step = NS_W'(STEP_NS);
    if (frac_sum[DATA_W])
      step = trim_neg ? step - NS_W'(1) : step + NS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (load) begin
      ns_q   <= {reg_wdata[HI_W-1:0], lo_stage_q};
      frac_q <= '0;
    end else if (!halt_q) begin
      ns_q   <= ns_q + step;
      frac_q <= frac_sum[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_stage_q <= '0;
      trim_q     <= '0;
      halt_q     <= 1'b1;
    end else if (reg_wr) begin
      if (reg_addr == A_LO)   lo_stage_q <= reg_wdata;
      if (reg_addr == A_TRIM) trim_q     <= reg_wdata;
      if (reg_addr == A_AUX)  halt_q     <= reg_wdata[DATA_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q    <= '0;
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_RES: begin
          reg_rdata <= frac_q;
          snap_q    <= ns_q;
        end
        A_LO:    reg_rdata <= snap_q[DATA_W-1:0];
        A_HI:    reg_rdata <= {{(DATA_W-HI_W){1'b0}}, snap_q[NS_W-1:DATA_W]};
        A_TRIM:  reg_rdata <= trim_q;
        A_AUX:   reg_rdata <= {halt_q, {(DATA_W-1){1'b0}}};
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign halt_o  = halt_q;
  assign time_ns = ns_q;
endmodule

module ns_time_counter_chk #(
  parameter int NS_W    = 40,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int STEP_NS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              halt_o,
  input logic [NS_W-1:0]   time_ns,
  input logic [DATA_W-1:0] trim_q,
  input logic [DATA_W-1:0] frac_q,
  input logic [NS_W-1:0]   snap_q
);
  localparam int HI_W = NS_W - DATA_W;
  wire ld = reg_wr && (reg_addr == ADDR_W'(2));

  a_r2_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !ld) |=> $stable(time_ns));

  a_r3_base_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_o && !ld && trim_q[DATA_W-2:0] == '0)
      |=> ((time_ns - $past(time_ns)) == NS_W'(STEP_NS)));

  a_r4_fast_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_o && !ld && !trim_q[DATA_W-1])
      |=> (((time_ns - $past(time_ns)) == NS_W'(STEP_NS)) ||
           ((time_ns - $past(time_ns)) == NS_W'(STEP_NS + 1))));

  a_r5_slow_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_o && !ld && trim_q[DATA_W-1])
      |=> (((time_ns - $past(time_ns)) == NS_W'(STEP_NS)) ||
           ((time_ns - $past(time_ns)) == NS_W'(STEP_NS - 1))));

  a_r6_hi_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(2)) |=> (reg_rdata[DATA_W-1:HI_W] == '0));

  a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_addr == ADDR_W'(0)) |=> $stable(snap_q));

  a_r8_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (frac_q == '0));
endmodule

bind ns_time_counter ns_time_counter_chk #(
  .NS_W(NS_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STEP_NS(STEP_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_rdata(reg_rdata), .halt_o(halt_o),
  .time_ns(time_ns), .trim_q(trim_q), .frac_q(frac_q), .snap_q(snap_q)
);

// File: tb/ns_time_counter_bench.sv
module ns_time_counter_bench;
  localparam logic [2:0] A_RES = 3'd0, A_LO = 3'd1, A_HI = 3'd2,
                         A_TRIM = 3'd3, A_AUX = 3'd4;
  localparam logic [31:0] HALT = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        halt_o;
  logic [39:0] time_ns;

  ns_time_counter u_ns_time_counter (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .halt_o(halt_o), .time_ns(time_ns)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 1'b0;

  logic [39:0] m_ns;
  logic [31:0] m_res, m_mag;
  logic        m_neg;

  task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(posedge clk) pend <= reg_rd;

  always @(negedge clk) begin
    if (pend) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(64'(reg_rdata), 64'(e), t);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic model_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      logic [32:0] s;
      s = {1'b0, m_res} + {2'b00, m_mag[30:0]};
      m_res = s[31:0];
      if (s[32]) m_ns = m_neg ? m_ns + 40'd7 : m_ns + 40'd9;
      else       m_ns = m_ns + 40'd8;
    end
  endtask

  task automatic run(input int n);
    wr(A_AUX, 32'h0);
    repeat (n - 1) @(negedge clk);
    wr(A_AUX, HALT);
    model_ticks(n);
  endtask

  task automatic load(input logic [39:0] v);
    wr(A_LO, v[31:0]);
    wr(A_HI, {24'hFFFFFF, v[39:32]});
    m_ns = v; m_res = '0;
  endtask

  task automatic set_trim(input logic [31:0] t);
    wr(A_TRIM, t);
    m_mag = t; m_neg = t[31];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_ns = '0; m_res = '0; m_mag = '0; m_neg = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(64'(time_ns), 64'd0, "R1 count");
    check(64'(halt_o), 64'd1, "R1 halt");
    check(64'(reg_rdata), 64'd0, "R1 rdata");
    rd(A_AUX, HALT, "R1 control word");
    rd(A_TRIM, 32'h0, "R1 trim");
    rd(A_RES, 32'h0, "R1 residue");

    // R2 halted count holds
    repeat (6) @(negedge clk);
    check(64'(time_ns), 64'd0, "R2 halted hold");

    // R3 base step
    run(10);
    check(64'(time_ns), 64'(m_ns), "R3 ten ticks");
    check(64'(time_ns), 64'd80, "R3 eighty ns");
    rd(A_RES, 32'h0, "R9 residue read");
    rd(A_LO, 32'd80, "R9 low read");
    rd(A_HI, 32'h0, "R6 high read zero");

    // R8 staged load
    wr(A_LO, 32'h1234_5678);
    repeat (2) @(negedge clk);
    check(64'(time_ns), 64'd80, "R8 low write alone");
    wr(A_HI, 32'hFFFF_FFAB);
    m_ns = 40'hAB_1234_5678; m_res = '0;
    check(64'(time_ns), 64'(m_ns), "R8 load value");
    rd(A_RES, 32'h0, "R8 residue after load");
    rd(A_HI, 32'h0000_00AB, "R6 high reserved bits");
    rd(A_LO, 32'h1234_5678, "R7 low from snapshot");

    // R4 positive trim
    set_trim(32'h4000_0000);
    run(6);
    check(64'(time_ns), 64'(m_ns), "R4 positive trim count");
    check(64'(time_ns), 64'(40'hAB_1234_5678 + 40'd49), "R4 one carry");
    rd(A_RES, m_res, "R10 residue value");

    // R10 residue write ignored
    wr(A_RES, 32'hDEAD_BEEF);
    rd(A_RES, m_res, "R10 residue write ignored");
    check(64'(time_ns), 64'(m_ns), "R10 count untouched");

    // R5 negative trim
    set_trim(32'hC000_0000);
    run(8);
    check(64'(time_ns), 64'(m_ns), "R5 negative trim count");
    check(64'(time_ns), 64'(40'hAB_1234_5678 + 40'd49 + 40'd62), "R5 two slow ticks");
    rd(A_RES, m_res, "R5 residue after slow run");

    // R8 load clears non-zero residue
    load(40'h01_0000_0100);
    rd(A_RES, 32'h0, "R8 residue cleared");

    // R7 snapshot while running
    set_trim(32'h0);
    load(40'h22_FFFF_FF00);
    wr(A_AUX, 32'h0);
    rd(A_RES, 32'h0, "R7 residue at capture");
    repeat (20) @(negedge clk);
    rd(A_LO, 32'hFFFF_FF00, "R7 low snapshot");
    rd(A_HI, 32'h0000_0022, "R7 high snapshot");
    wr(A_AUX, HALT);
    check(64'(time_ns != 40'h22_FFFF_FF00), 64'd1, "R7 live count moved");

    // R6 wrap at 2^40
    load(40'hFF_FFFF_FFFC);
    run(1);
    check(64'(time_ns), 64'd4, "R6 wrap");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule